// File: doc/BRIEF.md
# CAN Receive Message FIFO with Interrupt Flags

This block stores frames that a CAN controller's acceptance logic has already accepted and hands them to the CPU in arrival order. Each accepted frame arrives as a single-cycle write strobe. The strobe carries four words: control/status, identifier, data word 0 and data word 1. Up to six frames are held.

The CPU always sees the oldest stored frame through one fixed four-word output window. It learns what is happening from three interrupt flags: frames-available, warning and overflow. The CPU does not use a read strobe to release a frame. It writes 1 to the frames-available flag, which removes the frame in the window and moves the next one in.

A full output tells the upstream matching logic that a frame offered now would be refused. When a frame is refused, the overflow flag records it.

Top module: `can_rx_fifo`

## Requirements
- R1: The FIFO holds at most DEPTH (6) frames. `fifo_full` is 1 exactly when DEPTH frames are stored.
- R2: While frames are stored, the output window (`out_cs`, `out_id`, `out_d0`, `out_d1`) shows the oldest stored frame. Its four fields are exactly the four words written with that frame.
- R3: `flag_avail` is 1 if and only if at least one frame is stored. It becomes 1 in the cycle after the clock edge that stores a frame into an empty FIFO.
- R4: Writing 1 to `flag_w1c[0]` while frames are stored removes the frame in the window and presents the next one. `flag_avail` stays 1 while frames remain. Writing it while the FIFO is empty has no effect.
- R5: `flag_warn` is set at the clock edge where the stored count goes from below WARN_LEVEL (5) to WARN_LEVEL or more.
- R6: A frame offered with `push_valid` while the FIFO is full, and with no pop in the same cycle, is not stored. It sets `flag_overflow`, and the stored frames and the window stay unchanged.
- R7: `flag_warn` and `flag_overflow` are sticky. Writing 1 to `flag_w1c[1]` clears the warning flag and writing 1 to `flag_w1c[2]` clears the overflow flag. A new set event in the same cycle wins over a clear. A pop leaves both flags alone.
- R8: A push and a pop in the same cycle are both performed and the stored count does not change. This holds even when the FIFO is full, in which case the push is accepted and overflow is not set.
- R9: When the FIFO is empty, the output window holds the last frame that was removed.
- R10: After reset the FIFO is empty, all three flags are 0, `fifo_full` is 0 and the output window reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Accepted frame offered this cycle |
| push_cs | input | W | Control/status word of the offered frame |
| push_id | input | W | Identifier word of the offered frame |
| push_d0 | input | W | Data word 0 of the offered frame |
| push_d1 | input | W | Data word 1 of the offered frame |
| flag_w1c | input | 3 | Write-1-to-clear strobes: bit 0 = available (pop), bit 1 = warning, bit 2 = overflow |
| out_cs | output | W | Window: control/status of the oldest frame |
| out_id | output | W | Window: identifier of the oldest frame |
| out_d0 | output | W | Window: data word 0 of the oldest frame |
| out_d1 | output | W | Window: data word 1 of the oldest frame |
| flag_avail | output | 1 | Frames-available flag |
| flag_warn | output | 1 | Sticky warning flag |
| flag_overflow | output | 1 | Sticky overflow flag |
| fifo_full | output | 1 | FIFO cannot take a frame without a pop in the same cycle |

## Verification
Every result is due one clock edge after its stimulus. A push or pop presented before an edge changes the window, `flag_avail` and `fifo_full` right after that edge, and a set or clear of the sticky flags shows in the same post-edge cycle. The bench drives inputs at the falling edge and applies the same stimulus to a queue model at the rising edge. It then compares every output at the next falling edge, so each comparison lands exactly one edge after the stimulus that caused it. Directed sequences cover filling to full, a refused push, a push with a pop at full, clear-versus-set collisions and an empty pop. Seeded random traffic with biased push and pop rates follows.

// File: rtl/can_rx_fifo.sv
module can_rx_fifo #(
  parameter int DEPTH      = 6,
  parameter int WARN_LEVEL = 5,
  parameter int W          = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_valid,
  input  logic [W-1:0] push_cs,
  input  logic [W-1:0] push_id,
  input  logic [W-1:0] push_d0,
  input  logic [W-1:0] push_d1,
  input  logic [2:0]   flag_w1c,
  output logic [W-1:0] out_cs,
  output logic [W-1:0] out_id,
  output logic [W-1:0] out_d0,
  output logic [W-1:0] out_d1,
  output logic         flag_avail,
  output logic         flag_warn,
  output logic         flag_overflow,
  output logic         fifo_full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [CW-1:0] WARN_C  = CW'(WARN_LEVEL);
  localparam logic [PW-1:0] LAST_P  = PW'(DEPTH - 1);

  logic [W-1:0]  m_cs [DEPTH];
  logic [W-1:0]  m_id [DEPTH];
  logic [W-1:0]  m_d0 [DEPTH];
  logic [W-1:0]  m_d1 [DEPTH];
  logic [W-1:0]  h_cs, h_id, h_d0, h_d1;
  logic [PW-1:0] rd, wr;
  logic [CW-1:0] count, count_nx;
  logic          empty, pop, acc, warn_set, ovf_set;

  assign empty     = (count == '0);
  assign fifo_full = (count == DEPTH_C);
  assign pop       = flag_w1c[0] & ~empty;
  assign acc       = push_valid & (~fifo_full | pop);
  assign ovf_set   = push_valid & ~acc;
  assign count_nx  = count + CW'(acc) - CW'(pop);
  assign warn_set  = (count < WARN_C) & (count_nx >= WARN_C);

  assign flag_avail = ~empty;
  assign out_cs = empty ? h_cs : m_cs[rd];
  assign out_id = empty ? h_id : m_id[rd];
  assign out_d0 = empty ? h_d0 : m_d0[rd];
  assign out_d1 = empty ? h_d1 : m_d1[rd];

  always_ff @(posedge clk) begin
    if (acc) begin
      m_cs[wr] <= push_cs;
      m_id[wr] <= push_id;
      m_d0[wr] <= push_d0;
      m_d1[wr] <= push_d1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd    <= '0;
      wr    <= '0;
      count <= '0;
      h_cs  <= '0;
      h_id  <= '0;
      h_d0  <= '0;
      h_d1  <= '0;
    end else begin
      count <= count_nx;
      if (acc) wr <= (wr == LAST_P) ? '0 : wr + 1'b1;
      if (pop) begin
        rd   <= (rd == LAST_P) ? '0 : rd + 1'b1;
        h_cs <= m_cs[rd];
        h_id <= m_id[rd];
        h_d0 <= m_d0[rd];
        h_d1 <= m_d1[rd];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_warn     <= 1'b0;
      flag_overflow <= 1'b0;
    end else begin
      if (warn_set)         flag_warn <= 1'b1;
      else if (flag_w1c[1]) flag_warn <= 1'b0;
      if (ovf_set)          flag_overflow <= 1'b1;
      else if (flag_w1c[2]) flag_overflow <= 1'b0;
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= DEPTH_C); // R1
  AST_REFUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && fifo_full && !flag_w1c[0]) |=> (fifo_full && flag_overflow && $stable(out_id))); // R6
  AST_POP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_w1c[0] && flag_avail && !push_valid) |=> (count == $past(count) - 1'b1)); // R4
  AST_PUSHPOP_EQ: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_w1c[0] && flag_avail && push_valid) |=> ($stable(count) && !$rose(flag_overflow))); // R8
  AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_avail && !push_valid) |=> ($stable(out_cs) && $stable(out_id) && $stable(out_d0) && $stable(out_d1))); // R9
  AST_WARN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (count == WARN_C - 1'b1 && push_valid && !flag_w1c[0]) |=> flag_warn); // R5
endmodule

// File: tb/sim_can_rx_fifo.sv
module sim_can_rx_fifo;
  localparam int DEPTH = 6, WARN = 5, W = 32;
  logic clk = 0, rst_n = 0;
  logic push_valid = 0;
  logic [W-1:0] push_cs = 0, push_id = 0, push_d0 = 0, push_d1 = 0;
  logic [2:0] flag_w1c = 0;
  logic [W-1:0] out_cs, out_id, out_d0, out_d1;
  logic flag_avail, flag_warn, flag_overflow, fifo_full;

  always #4 clk = ~clk;

  can_rx_fifo #(.DEPTH(DEPTH), .WARN_LEVEL(WARN), .W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid),
    .push_cs(push_cs), .push_id(push_id), .push_d0(push_d0), .push_d1(push_d1),
    .flag_w1c(flag_w1c), .out_cs(out_cs), .out_id(out_id), .out_d0(out_d0), .out_d1(out_d1),
    .flag_avail(flag_avail), .flag_warn(flag_warn), .flag_overflow(flag_overflow),
    .fifo_full(fifo_full));

  int checks = 0, errors = 0;
  logic [4*W-1:0] q[$];
  logic [4*W-1:0] last = '0;
  logic e_warn = 0, e_ovf = 0;

  function automatic logic [4*W-1:0] exp_window();
    return (q.size() > 0) ? q[0] : last;
  endfunction

  task automatic chk(input string tag, input logic [4*W-1:0] act, input logic [4*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string wtag);
    chk(wtag, {out_cs, out_id, out_d0, out_d1}, exp_window());
    chk("R3", {127'd0, flag_avail}, {127'd0, q.size() > 0});
    chk("R1", {127'd0, fifo_full}, {127'd0, q.size() == DEPTH});
    chk("R5", {127'd0, flag_warn}, {127'd0, e_warn});
    chk("R6", {127'd0, flag_overflow}, {127'd0, e_ovf});
  endtask

  task automatic model_edge();
    int prev = q.size();
    logic pop = flag_w1c[0] && prev > 0;
    logic acc = push_valid && (prev < DEPTH || pop);
    logic ws;
    if (pop) last = q.pop_front();
    if (acc) q.push_back({push_cs, push_id, push_d0, push_d1});
    ws = (prev < WARN) && (q.size() >= WARN);
    e_warn = ws ? 1'b1 : (flag_w1c[1] ? 1'b0 : e_warn);
    e_ovf  = (push_valid && !acc) ? 1'b1 : (flag_w1c[2] ? 1'b0 : e_ovf);
  endtask

  task automatic cyc(input logic pv, input logic [2:0] c, input string wtag);
    push_valid = pv;
    flag_w1c   = c;
    push_cs = $urandom; push_id = $urandom; push_d0 = $urandom; push_d1 = $urandom;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    push_valid = 0;
    flag_w1c   = 0;
    check_all(wtag);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1C0FFEE));
    repeat (3) @(negedge clk);
    check_all("R10");
    rst_n = 1;
    @(negedge clk);
    check_all("R10");
    cyc(0, 3'b001, "R4");
    for (int i = 0; i < DEPTH; i++) cyc(1, 3'b000, "R2");
    cyc(1, 3'b000, "R6");
    cyc(1, 3'b000, "R6");
    cyc(1, 3'b001, "R8");
    cyc(0, 3'b110, "R7");
    cyc(1, 3'b100, "R7");
    cyc(0, 3'b001, "R7");
    for (int i = 0; i < DEPTH; i++) cyc(0, 3'b001, "R4");
    cyc(0, 3'b001, "R9");
    cyc(0, 3'b000, "R9");
    for (int i = 0; i < WARN; i++) cyc(1, 3'b000, "R5");
    cyc(1, 3'b011, "R7");
    cyc(0, 3'b111, "R7");
    for (int i = 0; i < 4000; i++) begin
      int mode = (i / 500) % 3;
      int lim  = (mode == 0) ? 70 : (mode == 1) ? 40 : 55;
      logic pv = ($urandom % 100) < lim;
      logic [2:0] c;
      c[0] = ($urandom % 100) < 50;
      c[1] = ($urandom % 100) < 10;
      c[2] = ($urandom % 100) < 10;
      cyc(pv, c, "R2");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule